// File: doc/BRIEF.md
# 64-bit Compare Timer

This block holds a free-running 64-bit up-counter and one 64-bit compare channel, both reached through a plain 32-bit register bus. Each 64-bit quantity is split into a low and a high word. Software starts or holds the counter with a control bit. It loads a compare value and enables the channel. When the counter reaches that value, a status flag is raised. A level interrupt follows the flag while the interrupt enable is set.

For periodic events the channel can re-arm itself. On each match it adds a programmed 32-bit step to its own compare value, so the next match falls one period later and software does not have to reprogram it. Reads have no side effects. Software can therefore take a coherent 64-bit snapshot of the running counter by reading high, low, high and retrying when the two high words differ.

The bus is a single-cycle strobe. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`. The asynchronous reset is released through a two-stage synchronizer.

Top module: `cmp_timer64`

## Requirements
- R1: After reset, all registers read zero: counter, comparator, step, control, status and enable. `irq` is low.
- R2: The counter advances by exactly one per clock while the run bit (bit 8 of the control word at 0x240) is set. It holds its value while that bit is clear.
- R3: The counter low word (0x100) and high word (0x104) can be written. The written word takes the written value on that edge. A carry out of the low word increments the high word.
- R4: Reading any register has no side effect, so the counter keeps its normal pace across any sequence of reads.
- R5: The comparator low word (0x200), comparator high word (0x204) and the 32-bit step (0x208) read back what was written.
- R6: The status flag (bit 0 at 0x244) is set on the edge that follows a cycle in which the compare-enable bit (control bit 0) is set and the counter equals the comparator. No match occurs while the compare-enable bit is clear.
- R7: When the auto-step bit (control bit 1) is set, a match adds the step, zero-extended, to the comparator. When that bit is clear, the comparator keeps its value after a match.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves the flag unchanged.
- R9: If a match coincides with a clearing write, the flag stays set.
- R10: `irq` is high exactly while the flag and the interrupt enable (bit 0 at 0x248) are both set.
- R11: An address outside the map reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt: flag AND enable |

## Verification
The hardest case to reach from the ports is a match that lands on the same edge as a clearing write. The bench sets it up by stopping the counter on a value equal to the comparator. With compare enabled, this makes the match true on every cycle, so the clear is certain to collide with it. The auto-step path is driven the same way, from a stopped counter, so the first step happens on a known edge. The counter is then started, and the second match is found by polling the flag every cycle and checking the counter value at that moment.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  // Register byte offsets decoded by software drivers
  localparam logic [11:0] OFS_CNT_LO  = 12'h100;
  localparam logic [11:0] OFS_CMP_LO  = 12'h200;
  localparam logic [11:0] OFS_STEP    = 12'h208;
  localparam logic [11:0] OFS_CTRL    = 12'h240;
  localparam logic [11:0] OFS_STAT    = 12'h244;
  localparam logic [11:0] OFS_IEN     = 12'h248;
  localparam int          WORD_BYTES  = 4;

  // Control word bit positions
  localparam int CTRL_RUN_BIT  = 8;
  localparam int CTRL_STEP_BIT = 1;
  localparam int CTRL_CEN_BIT  = 0;

  typedef struct packed {
    logic run;
    logic auto_step;
    logic cmp_en;
  } ctrl_t;

endpackage

// File: rtl/cmp_timer_rst_sync.sv
module cmp_timer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int HALF_W = 32,
  parameter int HALVES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [HALVES-1:0]        wr_half,
  input  logic [HALF_W-1:0]        wdata,
  output logic [HALVES*HALF_W-1:0] count
);

  localparam int CNT_W = HALVES * HALF_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign cnt_ce  = run | (|wr_half);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign cnt_d[h*HALF_W +: HALF_W] =
      wr_half[h] ? wdata :
      (run ? cnt_inc[h*HALF_W +: HALF_W] : cnt_q[h*HALF_W +: HALF_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R2: steady advance while running and not written
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(|wr_half)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R2: holds while stopped and not written
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(|wr_half)) |=> $stable(cnt_q));

  // R3: a written low word takes the bus value
  a_r3_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_half[0] |=> (cnt_q[HALF_W-1:0] == $past(wdata)));

endmodule

// File: rtl/cmp_timer_cmp_chan.sv
module cmp_timer_cmp_chan #(
  parameter int HALF_W = 32,
  parameter int HALVES = 2,
  parameter int STEP_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmp_en,
  input  logic                     auto_step,
  input  logic [HALVES*HALF_W-1:0] count,
  input  logic [STEP_W-1:0]        step,
  input  logic [HALVES-1:0]        wr_half,
  input  logic [HALF_W-1:0]        wdata,
  input  logic                     clr_req,
  output logic [HALVES*HALF_W-1:0] comp,
  output logic                     flag
);

  localparam int CNT_W = HALVES * HALF_W;

  logic [CNT_W-1:0] comp_q;
  logic [CNT_W-1:0] comp_d;
  logic [CNT_W-1:0] comp_sum;
  logic             comp_ce;
  logic             hit;
  logic             rearm;
  logic             flag_q;
  logic             flag_d;

  assign hit      = cmp_en && (count == comp_q);
  assign rearm    = hit && auto_step;
  assign comp_sum = comp_q + CNT_W'(step);
  assign comp_ce  = rearm | (|wr_half);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign comp_d[h*HALF_W +: HALF_W] =
      wr_half[h] ? wdata :
      (rearm ? comp_sum[h*HALF_W +: HALF_W] : comp_q[h*HALF_W +: HALF_W]);
  end

  // set dominates clear
  assign flag_d = hit | (flag_q & ~clr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       comp_q <= '0;
    else if (comp_ce) comp_q <= comp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign comp = comp_q;
  assign flag = flag_q;

  // R6: equality while enabled raises the flag on the next edge
  a_r6_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && (count == comp_q)) |=> flag_q);

  // R6: no new flag without enable
  a_r6_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !cmp_en) |=> !flag_q);

  // R7: auto-step adds the step after a match
  a_r7_step_add: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && auto_step && (count == comp_q) && !(|wr_half))
      |=> (comp_q == $past(comp_q) + CNT_W'($past(step))));

  // R7: comparator otherwise untouched
  a_r7_comp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|wr_half) && !(cmp_en && auto_step && (count == comp_q))) |=> $stable(comp_q));

  // R8: clear without a coinciding match drops the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !(cmp_en && (count == comp_q))) |=> !flag_q);

  // R9: match beats a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && cmp_en && (count == comp_q)) |=> flag_q);

endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int HALF_W = 32,
  parameter int HALVES = 2,
  parameter int STEP_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [HALF_W-1:0]        bus_wdata,
  output logic [HALF_W-1:0]        bus_rdata,
  input  logic [HALVES*HALF_W-1:0] count,
  input  logic [HALVES*HALF_W-1:0] comp,
  input  logic                     flag,
  output ctrl_t                    ctrl,
  output logic [STEP_W-1:0]        step,
  output logic                     ien,
  output logic [HALVES-1:0]        cnt_wr,
  output logic [HALVES-1:0]        cmp_wr,
  output logic                     clr_req
);

  logic  wr_en;
  logic  ctrl_wr, step_wr, stat_wr, ien_wr;
  ctrl_t ctrl_q, ctrl_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic  ien_q, ien_d;

  assign wr_en   = bus_sel & bus_wr;
  assign ctrl_wr = wr_en && (bus_addr == ADDR_W'(OFS_CTRL));
  assign step_wr = wr_en && (bus_addr == ADDR_W'(OFS_STEP));
  assign stat_wr = wr_en && (bus_addr == ADDR_W'(OFS_STAT));
  assign ien_wr  = wr_en && (bus_addr == ADDR_W'(OFS_IEN));
  assign clr_req = stat_wr && bus_wdata[0];

  for (genvar h = 0; h < HALVES; h++) begin : g_wr
    assign cnt_wr[h] = wr_en && (bus_addr == ADDR_W'(OFS_CNT_LO + 12'(WORD_BYTES*h)));
    assign cmp_wr[h] = wr_en && (bus_addr == ADDR_W'(OFS_CMP_LO + 12'(WORD_BYTES*h)));
  end

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    step_d = step_q;
    ien_d  = ien_q;
    if (ctrl_wr) begin
      ctrl_d.run       = bus_wdata[CTRL_RUN_BIT];
      ctrl_d.auto_step = bus_wdata[CTRL_STEP_BIT];
      ctrl_d.cmp_en    = bus_wdata[CTRL_CEN_BIT];
    end
    if (step_wr) step_d = STEP_W'(bus_wdata);
    if (ien_wr)  ien_d  = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      step_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_d;
      if (step_wr) step_q <= step_d;
      if (ien_wr)  ien_q  <= ien_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int h = 0; h < HALVES; h++) begin
      if (bus_addr == ADDR_W'(OFS_CNT_LO + 12'(WORD_BYTES*h))) bus_rdata = count[h*HALF_W +: HALF_W];
      if (bus_addr == ADDR_W'(OFS_CMP_LO + 12'(WORD_BYTES*h))) bus_rdata = comp[h*HALF_W +: HALF_W];
    end
    if (bus_addr == ADDR_W'(OFS_STEP)) bus_rdata = HALF_W'(step_q);
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      bus_rdata[CTRL_RUN_BIT]  = ctrl_q.run;
      bus_rdata[CTRL_STEP_BIT] = ctrl_q.auto_step;
      bus_rdata[CTRL_CEN_BIT]  = ctrl_q.cmp_en;
    end
    if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata[0] = flag;
    if (bus_addr == ADDR_W'(OFS_IEN))  bus_rdata[0] = ien_q;
  end

  assign ctrl = ctrl_q;
  assign step = step_q;
  assign ien  = ien_q;

  // R11: control only changes through its own address
  a_r11_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (bus_addr == ADDR_W'(OFS_CTRL))) |=> $stable(ctrl_q));

  // R4: a read strobe never alters the enable or step
  a_r4_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> ($stable(step_q) && $stable(ien_q)));

endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int STEP_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam int HALVES = 2;
  localparam int CNT_W  = HALVES * BUS_W;

  logic              rst_n;
  ctrl_t             ctrl;
  logic [STEP_W-1:0] step;
  logic              ien;
  logic [HALVES-1:0] cnt_wr;
  logic [HALVES-1:0] cmp_wr;
  logic              clr_req;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  comp;
  logic              flag;

  cmp_timer_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  cmp_timer_regs #(
    .ADDR_W(ADDR_W), .HALF_W(BUS_W), .HALVES(HALVES), .STEP_W(STEP_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .count     (count),
    .comp      (comp),
    .flag      (flag),
    .ctrl      (ctrl),
    .step      (step),
    .ien       (ien),
    .cnt_wr    (cnt_wr),
    .cmp_wr    (cmp_wr),
    .clr_req   (clr_req)
  );

  cmp_timer_counter #(.HALF_W(BUS_W), .HALVES(HALVES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.run),
    .wr_half (cnt_wr),
    .wdata   (bus_wdata),
    .count   (count)
  );

  cmp_timer_cmp_chan #(.HALF_W(BUS_W), .HALVES(HALVES), .STEP_W(STEP_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_en    (ctrl.cmp_en),
    .auto_step (ctrl.auto_step),
    .count     (count),
    .step      (step),
    .wr_half   (cmp_wr),
    .wdata     (bus_wdata),
    .clr_req   (clr_req),
    .comp      (comp),
    .flag      (flag)
  );

  assign irq = flag & ien;

  // R10: interrupt output tracks the flag once enabled
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ien |-> (irq == flag));

endmodule

// File: tb/cmp_timer64_tb.sv
`timescale 1ns/1ps
module cmp_timer64_tb;

  localparam logic [11:0] A_CNT_LO = 12'h100;
  localparam logic [11:0] A_CNT_HI = 12'h104;
  localparam logic [11:0] A_CMP_LO = 12'h200;
  localparam logic [11:0] A_CMP_HI = 12'h204;
  localparam logic [11:0] A_STEP   = 12'h208;
  localparam logic [11:0] A_CTRL   = 12'h240;
  localparam logic [11:0] A_STAT   = 12'h244;
  localparam logic [11:0] A_IEN    = 12'h248;
  localparam logic [11:0] A_NONE   = 12'h300;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  cmp_timer64 u_dut (
    .clk(clk), .arst_n(arst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic poll_flag(input int maxc, output bit seen);
    logic [31:0] v;
    seen = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      rd(A_STAT, v);
      if (v[0]) begin seen = 1'b1; return; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CNT_LO, v); check("R1 cnt lo", v, 0);
    rd(A_CNT_HI, v); check("R1 cnt hi", v, 0);
    rd(A_CMP_LO, v); check("R1 cmp lo", v, 0);
    rd(A_STEP, v);   check("R1 step", v, 0);
    rd(A_CTRL, v);   check("R1 ctrl", v, 0);
    rd(A_STAT, v);   check("R1 stat", v, 0);
    rd(A_IEN, v);    check("R1 ien", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_run_hold();
    logic [31:0] a, b, h0, h1;
    wr(A_CTRL, 32'h100);
    rd(A_CNT_LO, a);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      rd(A_CNT_HI, h0); rd(A_CNT_LO, b); rd(A_CNT_HI, h1);
    end
    check("R2 R4 advance under reads", b - a, 7);
    check("R4 upper stable", h1, h0);
    wr(A_CTRL, 32'h0);
    rd(A_CNT_LO, a);
    repeat (5) @(negedge clk);
    rd(A_CNT_LO, b);
    check("R2 hold when stopped", b, a);
  endtask

  task automatic t_carry();
    logic [31:0] v;
    wr(A_CNT_LO, 32'hFFFF_FFFE);
    wr(A_CNT_HI, 32'h0000_0005);
    rd(A_CNT_LO, v); check("R3 lo written", v, 32'hFFFF_FFFE);
    rd(A_CNT_HI, v); check("R3 hi written", v, 32'h5);
    wr(A_CTRL, 32'h100);
    repeat (3) @(negedge clk);
    rd(A_CNT_LO, v); check("R3 carry lo", v, 32'h1);
    rd(A_CNT_HI, v); check("R3 carry hi", v, 32'h6);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_CMP_LO, 32'hDEAD_BEEF);
    wr(A_CMP_HI, 32'h1234_5678);
    wr(A_STEP,   32'hCAFE_F00D);
    rd(A_CMP_LO, v); check("R5 cmp lo", v, 32'hDEAD_BEEF);
    rd(A_CMP_HI, v); check("R5 cmp hi", v, 32'h1234_5678);
    rd(A_STEP, v);   check("R5 step", v, 32'hCAFE_F00D);
    wr(A_NONE, 32'hFFFF_FFFF);
    rd(A_NONE, v);   check("R11 unmapped reads zero", v, 0);
    rd(A_CTRL, v);   check("R11 ctrl untouched", v, 0);
    rd(A_STEP, v);   check("R11 step untouched", v, 32'hCAFE_F00D);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    bit seen;
    wr(A_CNT_LO, 200); wr(A_CNT_HI, 0);
    wr(A_CMP_LO, 205); wr(A_CMP_HI, 0);
    wr(A_CTRL, 32'h100);
    repeat (20) @(negedge clk);
    rd(A_STAT, v); check("R6 no match when disabled", v, 0);
    wr(A_CTRL, 32'h0);
    wr(A_CNT_LO, 100);
    wr(A_CMP_LO, 110);
    wr(A_IEN, 1);
    wr(A_CTRL, 32'h101);
    poll_flag(50, seen);
    check("R6 flag raised", {31'd0, seen}, 1);
    rd(A_CNT_LO, v); check("R6 flag one edge after equality", v, 111);
    check("R10 irq with enable", {31'd0, irq}, 1);
    rd(A_CMP_LO, v); check("R7 no step without auto", v, 110);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 0);
    rd(A_STAT, v); check("R8 write 0 keeps flag", v, 1);
    wr(A_STAT, 1);
    rd(A_STAT, v); check("R8 write 1 clears", v, 0);
    check("R10 irq low after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_auto();
    logic [31:0] v;
    bit seen;
    wr(A_CNT_LO, 1000);
    wr(A_CMP_LO, 1000); wr(A_CMP_HI, 0);
    wr(A_STEP, 50);
    wr(A_CTRL, 32'h003);
    repeat (3) @(negedge clk);
    rd(A_CMP_LO, v); check("R7 single step on match", v, 1050);
    rd(A_STAT, v);   check("R6 flag on stopped match", v, 1);
    wr(A_STAT, 1);
    rd(A_STAT, v);   check("R8 cleared after step", v, 0);
    wr(A_CTRL, 32'h103);
    poll_flag(100, seen);
    check("R7 periodic match seen", {31'd0, seen}, 1);
    rd(A_CNT_LO, v); check("R7 match at stepped value", v, 1051);
    rd(A_CMP_LO, v); check("R7 re-armed", v, 1100);
    wr(A_IEN, 0);
    rd(A_STAT, v);   check("R10 flag still set", v, 1);
    check("R10 irq masked", {31'd0, irq}, 0);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 1);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    wr(A_CNT_LO, 3000);
    wr(A_CMP_LO, 3000);
    wr(A_CTRL, 32'h001);
    repeat (2) @(negedge clk);
    rd(A_STAT, v); check("R6 held equality sets flag", v, 1);
    wr(A_STAT, 1);
    rd(A_STAT, v); check("R9 set wins over clear", v, 1);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 1);
    rd(A_STAT, v); check("R8 clear once disabled", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    arst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_run_hold();
    t_carry();
    t_regs();
    t_oneshot();
    t_auto();
    t_set_wins();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule